// File: doc/BRIEF.md
# Three-Personality Cartridge Bank Mapper

The block is the bank mapper of a game cartridge for an 8-bit console. A run-time mode register picks one of three mapper personalities: a nibble-loaded 1 KB CHR mapper with two switchable 8 KB PRG windows, an indexed bank-register mapper with PRG and CHR window swapping, or a serial-register mapper whose registers come from a separate shift loader. It decodes CPU writes into its own bank registers and turns the CPU read address and the picture-bus pattern address into bank-extended PRG and CHR ROM addresses and a nametable mirroring select.

Bank outputs are combinational from the registers, so a register write is visible on the first access after the write edge. The serial loader for the third personality and the scanline interrupt counter live outside and are not part of this block. The loader's four 5-bit registers arrive as plain inputs.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write whose address lies in 0x4100..0x7FFF with address bits 14 and 8 both set loads `cpu_data[2:0]` into the mode register; any other write leaves the mode unchanged.
- R2: Mode bits 1:0 pick the personality (0: nibble mapper "A", 1: indexed mapper "B", 2 or 3: serial mapper "C"). In personalities A and B, mode bit 2 appears as bit 8 of the 1 KB CHR bank (`chr_addr[18]`); in C that bit is 0.
- R3: In A, the 8 KB PRG bank (`prg_addr[20:13]`) is the register written at 0x8xxx for 0x8000-0x9FFF, the register written at 0xAxxx for 0xA000-0xBFFF, 0xFE for 0xC000-0xDFFF and 0xFF for 0xE000-0xFFFF.
- R4: In A, a write in 0xB000..0xE003 updates one nibble of CHR register k, with k[0] = A1|A11 and k[2:1] = A13:A12 + 1 (mod 4); A0 set writes the high nibble from `cpu_data[3:0]`, A0 clear the low nibble, and the other nibble is kept. Register k supplies the 1 KB window `ppu_addr[12:10]` = k.
- R5: In A a write at 0x9xxx, and in B a write decoded as 0xA000, stores a mirroring bit; bit value 0 gives `mirr_sel` = 2 (vertical) and 1 gives 3 (horizontal).
- R6: In B, writes decode on address bits 15, 14, 13 and 0: 0x8000 loads the control register (bits 2:0 select the target), 0x8001 writes the selected bank register, 0xA000 writes mirroring; 0xA001 and the 0xC000/0xE000 groups change nothing here.
- R7: In B, control bit 6 clear maps 0x8000 to register 6 and 0xC000 to the fixed bank 0xFE; set swaps these two. 0xA000 uses register 7 and 0xE000 is fixed at 0xFF.
- R8: In B, the CHR window is `ppu_addr[12:10]` XOR (control bit 7 ? 4 : 0); windows 0/1 take register 0 with bit 0 forced to 0/1, windows 2/3 do the same with register 1, windows 4..7 take registers 2..5.
- R9: In C, the PRG bank is `ser_prg[3:0]`; with `ser_ctrl[3]` clear a 32 KB window uses that bank shifted right by one; with bits 3 and 2 set the bank maps at 0x8000 and 16 KB bank 15 at 0xC000; with bit 3 set and bit 2 clear 16 KB bank 0 maps at 0x8000 and the bank at 0xC000.
- R10: In C, `ser_ctrl[4]` set gives two 4 KB CHR windows from `ser_chr_lo` and `ser_chr_hi`, clear gives one 8 KB window from `ser_chr_lo` shifted right by one; `mirr_sel` equals `ser_ctrl[1:0]` (0 single-screen A, 1 single-screen B, 2 vertical, 3 horizontal).
- R11: After reset the mode is 0, A's CHR registers are {FF,FF,FF,FF,04,05,06,07}, A's PRG registers are {00,01}, B's bank registers 0..7 are {00,02,04,05,06,07,FC,FD}, and both control and mirroring registers are 0.
- R12: Each personality's registers keep their values while another personality is active; writes in one mode never alter the other mode's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset to power-on values |
| cpu_addr | input | 16 | CPU address, used for write decode and PRG translation |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| ppu_addr | input | 13 | Picture-bus pattern address |
| ser_ctrl | input | 5 | Serial mapper control register |
| ser_chr_lo | input | 5 | Serial mapper first CHR register |
| ser_chr_hi | input | 5 | Serial mapper second CHR register |
| ser_prg | input | 5 | Serial mapper PRG register |
| prg_addr | output | 21 | Bank-extended PRG ROM address |
| chr_addr | output | 19 | Bank-extended CHR ROM address |
| mirr_sel | output | 2 | Mirroring select: 0/1 single-screen, 2 vertical, 3 horizontal |

## Verification
The hardest case to reach from the ports is proving that one personality's registers survive traffic aimed at another, because the overlapping write addresses only show up in the bank outputs once the mode is switched back. The stimulus programs the nibble mapper, switches to the indexed mapper and writes at addresses that would have hit those same registers, then returns to mode 0 and reads the untouched banks back. The nibble index formula is reached through aliased addresses such as 0xC800 and 0xE002, and the indexed decode through mirrored addresses such as 0x9FFE.

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_data,
  input  logic        cpu_wr,
  input  logic [12:0] ppu_addr,
  input  logic [4:0]  ser_ctrl,
  input  logic [4:0]  ser_chr_lo,
  input  logic [4:0]  ser_chr_hi,
  input  logic [4:0]  ser_prg,
  output logic [20:0] prg_addr,
  output logic [18:0] chr_addr,
  output logic [1:0]  mirr_sel
);

  logic [2:0] mode_q;
  logic [7:0] vchr [8];
  logic [7:0] vprg [2];
  logic       vmir;
  logic [7:0] bk [8];
  logic [7:0] bctl;
  logic       bmir;

  wire mode_hit = cpu_wr && cpu_addr >= 16'h4100 && cpu_addr <= 16'h7FFF
                  && cpu_addr[14] && cpu_addr[8];
  wire rom_wr   = cpu_wr && cpu_addr[15];
  wire nib_hit  = cpu_addr >= 16'hB000 && cpu_addr <= 16'hE003;
  wire [2:0] nib_idx = {cpu_addr[13:12] + 2'd1, cpu_addr[1] | cpu_addr[11]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'd0;
      for (int i = 0; i < 4; i++) vchr[i] <= 8'hFF;
      for (int i = 4; i < 8; i++) vchr[i] <= 8'(i);
      vprg[0] <= 8'h00;
      vprg[1] <= 8'h01;
      vmir    <= 1'b0;
      bk[0] <= 8'h00; bk[1] <= 8'h02; bk[2] <= 8'h04; bk[3] <= 8'h05;
      bk[4] <= 8'h06; bk[5] <= 8'h07; bk[6] <= 8'hFC; bk[7] <= 8'hFD;
      bctl <= 8'h00;
      bmir <= 1'b0;
    end else if (mode_hit) begin
      mode_q <= cpu_data[2:0];
    end else if (rom_wr) begin
      case (mode_q[1:0])
        2'd0: begin
          if (nib_hit) begin
            if (cpu_addr[0]) vchr[nib_idx][7:4] <= cpu_data[3:0];
            else             vchr[nib_idx][3:0] <= cpu_data[3:0];
          end else begin
            case (cpu_addr[15:12])
              4'h8: vprg[0] <= cpu_data;
              4'h9: vmir    <= cpu_data[0];
              4'hA: vprg[1] <= cpu_data;
              default: ;
            endcase
          end
        end
        2'd1: begin
          case ({cpu_addr[14:13], cpu_addr[0]})
            3'b000: bctl <= cpu_data;
            3'b001: bk[bctl[2:0]] <= cpu_data;
            3'b010: bmir <= cpu_data[0];
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  // PRG translation, 8 KB bank granularity
  logic [7:0] prg_bank;
  logic [3:0] sbank;
  assign sbank = ser_prg[3:0];

  always_comb begin
    prg_bank = 8'h00;
    case (mode_q[1:0])
      2'd0: case (cpu_addr[14:13])
        2'd0: prg_bank = vprg[0];
        2'd1: prg_bank = vprg[1];
        2'd2: prg_bank = 8'hFE;
        default: prg_bank = 8'hFF;
      endcase
      2'd1: case (cpu_addr[14:13])
        2'd0: prg_bank = bctl[6] ? 8'hFE : bk[6];
        2'd1: prg_bank = bk[7];
        2'd2: prg_bank = bctl[6] ? bk[6] : 8'hFE;
        default: prg_bank = 8'hFF;
      endcase
      default: begin
        if (!ser_ctrl[3])
          prg_bank = {3'b000, sbank[3:1], cpu_addr[14:13]};
        else if (ser_ctrl[2])
          prg_bank = {3'b000, cpu_addr[14] ? 4'hF : sbank, cpu_addr[13]};
        else
          prg_bank = {3'b000, cpu_addr[14] ? sbank : 4'h0, cpu_addr[13]};
      end
    endcase
  end

  assign prg_addr = {prg_bank, cpu_addr[12:0]};

  // CHR translation, 1 KB bank granularity
  logic [8:0] chr_bank;
  logic [2:0] win;
  logic [2:0] bwin;
  assign win  = ppu_addr[12:10];
  assign bwin = win ^ {bctl[7], 2'b00};

  always_comb begin
    chr_bank = 9'h000;
    case (mode_q[1:0])
      2'd0: chr_bank = {mode_q[2], vchr[win]};
      2'd1: case (bwin)
        3'd0: chr_bank = {mode_q[2], bk[0][7:1], 1'b0};
        3'd1: chr_bank = {mode_q[2], bk[0][7:1], 1'b1};
        3'd2: chr_bank = {mode_q[2], bk[1][7:1], 1'b0};
        3'd3: chr_bank = {mode_q[2], bk[1][7:1], 1'b1};
        default: chr_bank = {mode_q[2], bk[bwin - 3'd2]};
      endcase
      default: begin
        if (ser_ctrl[4])
          chr_bank = {2'b00, win[2] ? ser_chr_hi : ser_chr_lo, win[1:0]};
        else
          chr_bank = {2'b00, ser_chr_lo[4:1], win};
      end
    endcase
  end

  assign chr_addr = {chr_bank, ppu_addr[9:0]};

  always_comb begin
    case (mode_q[1:0])
      2'd0:    mirr_sel = {1'b1, vmir};
      2'd1:    mirr_sel = {1'b1, bmir};
      default: mirr_sel = ser_ctrl[1:0];
    endcase
  end

endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_data,
  input logic        cpu_wr,
  input logic [2:0]  mode_q,
  input logic [7:0]  vchr0,
  input logic [4:0]  ser_ctrl,
  input logic [20:0] prg_addr,
  input logic [18:0] chr_addr,
  input logic [1:0]  mirr_sel
);

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr >= 16'h4100 && cpu_addr <= 16'h7FFF && cpu_addr[14] && cpu_addr[8])
      |=> mode_q == $past(cpu_data[2:0])); // R1

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> $stable(mode_q)); // R1

  AST_CHR_HIGH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[1] |-> chr_addr[18] == mode_q[2]); // R2

  AST_SER_NO_HIGH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] |-> !chr_addr[18]); // R2

  AST_NIB_FIXED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'd0 && cpu_addr[15:13] == 3'b111) |-> prg_addr[20:13] == 8'hFF); // R3

  AST_NIB_HIGH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && mode_q[1:0] == 2'd0 && cpu_addr == 16'hB001)
      |=> (vchr0[3:0] == $past(vchr0[3:0]) && vchr0[7:4] == $past(cpu_data[3:0]))); // R4

  AST_IDX_FIXED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'd1 && cpu_addr[15:13] == 3'b111) |-> prg_addr[20:13] == 8'hFF); // R7

  AST_SER_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] |-> mirr_sel == ser_ctrl[1:0]); // R10

endmodule

bind cart_bank_mapper cart_bank_mapper_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_addr (cpu_addr),
  .cpu_data (cpu_data),
  .cpu_wr   (cpu_wr),
  .mode_q   (mode_q),
  .vchr0    (vchr[0]),
  .ser_ctrl (ser_ctrl),
  .prg_addr (prg_addr),
  .chr_addr (chr_addr),
  .mirr_sel (mirr_sel)
);

// File: tb/cart_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module cart_bank_mapper_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        cpu_wr = 1'b0;
  logic [12:0] ppu_addr = 13'h0000;
  logic [4:0]  ser_ctrl = 5'h0C;
  logic [4:0]  ser_chr_lo = 5'h00;
  logic [4:0]  ser_chr_hi = 5'h00;
  logic [4:0]  ser_prg = 5'h00;
  logic [20:0] prg_addr;
  logic [18:0] chr_addr;
  logic [1:0]  mirr_sel;

  int n_run = 0;
  int n_fail = 0;
  bit reported = 1'b0;

  always #2 clk = ~clk;

  cart_bank_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .ser_ctrl(ser_ctrl),
    .ser_chr_lo(ser_chr_lo), .ser_chr_hi(ser_chr_hi), .ser_prg(ser_prg),
    .prg_addr(prg_addr), .chr_addr(chr_addr), .mirr_sel(mirr_sel)
  );

  typedef struct packed {
    logic [4:0]  ctrl;
    logic [4:0]  clo;
    logic [4:0]  chi;
    logic [4:0]  prg;
    logic [15:0] a;
    logic [12:0] p;
    logic [7:0]  exp_prg;
    logic [8:0]  exp_chr;
    logic [1:0]  exp_mir;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t TBL [NV] = '{
    '{5'h0C, 5'h07, 5'h00, 5'h05, 16'h8000, 13'h0400, 8'h0A, 9'h019, 2'd0},
    '{5'h0C, 5'h07, 5'h00, 5'h05, 16'hE000, 13'h1C00, 8'h1F, 9'h01F, 2'd0},
    '{5'h09, 5'h06, 5'h00, 5'h05, 16'hC000, 13'h0000, 8'h0A, 9'h018, 2'd1},
    '{5'h12, 5'h00, 5'h09, 5'h07, 16'hE000, 13'h1400, 8'h0F, 9'h025, 2'd2},
    '{5'h13, 5'h1F, 5'h00, 5'h1F, 16'h8000, 13'h0C00, 8'h1C, 9'h07F, 2'd3},
    '{5'h1C, 5'h02, 5'h00, 5'h13, 16'hC000, 13'h0800, 8'h1E, 9'h00A, 2'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a, input logic [12:0] p);
    @(negedge clk);
    cpu_addr = a; ppu_addr = p;
    #1;
  endtask

  task automatic prg_is(input string tag, input logic [15:0] a, input logic [7:0] exp);
    probe(a, ppu_addr);
    check(tag, {11'd0, prg_addr}, {11'd0, exp, a[12:0]});
  endtask

  task automatic chr_is(input string tag, input logic [12:0] p, input logic [8:0] exp);
    probe(cpu_addr, p);
    check(tag, {13'd0, chr_addr}, {13'd0, exp, p[9:0]});
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state, nibble mapper
    prg_is("R11 R3 prg 8000", 16'h8000, 8'h00);
    prg_is("R11 R3 prg A000", 16'hA123, 8'h01);
    prg_is("R3 prg C000 fixed", 16'hC456, 8'hFE);
    prg_is("R3 prg E000 fixed", 16'hFFFF, 8'hFF);
    chr_is("R11 chr w0", 13'h0000, 9'h0FF);
    chr_is("R11 chr w3", 13'h0C00, 9'h0FF);
    chr_is("R11 chr w4", 13'h1000, 9'h004);
    chr_is("R11 chr w7", 13'h1FFF, 9'h007);
    check("R11 R5 mirr", 32'(mirr_sel), 32'd2);

    // R4 nibble writes
    wr(16'hB000, 8'hC3);
    chr_is("R4 low nibble", 13'h0000, 9'h0F3);
    wr(16'hB001, 8'h5A);
    chr_is("R4 high nibble", 13'h0000, 9'h0A3);
    wr(16'hE002, 8'h01);
    chr_is("R4 idx7 via E002", 13'h1C00, 9'h001);
    wr(16'hC800, 8'h02);
    chr_is("R4 idx3 via C800", 13'h0C00, 9'h0F2);
    chr_is("R4 idx2 untouched", 13'h0800, 9'h0FF);

    // R3 switchable PRG
    wr(16'h8123, 8'h21);
    wr(16'hA000, 8'h33);
    prg_is("R3 prg0 written", 16'h8000, 8'h21);
    prg_is("R3 prg1 written", 16'hBFFF, 8'h33);

    // R5 mirroring in nibble mapper
    wr(16'h9000, 8'h01);
    probe(16'h8000, 13'h0);
    check("R5 horizontal", 32'(mirr_sel), 32'd3);
    wr(16'h9000, 8'h00);
    probe(16'h8000, 13'h0);
    check("R5 vertical", 32'(mirr_sel), 32'd2);

    // R1 mode decode
    wr(16'h4200, 8'h01);
    prg_is("R1 ignored 4200", 16'hC000, 8'hFE);
    wr(16'h5101, 8'h05);
    chr_is("R1 R2 mode5 w0", 13'h0000, 9'h100);
    chr_is("R11 R8 idx w1", 13'h0400, 9'h101);
    chr_is("R11 R8 idx w3", 13'h0C00, 9'h103);
    chr_is("R11 R8 idx w6", 13'h1800, 9'h106);
    prg_is("R11 R7 reg6", 16'h8000, 8'hFC);
    prg_is("R11 R7 reg7", 16'hA000, 8'hFD);
    prg_is("R7 C000 fixed FE", 16'hC000, 8'hFE);
    prg_is("R7 E000 fixed FF", 16'hE000, 8'hFF);
    check("R11 R5 idx mirr", 32'(mirr_sel), 32'd2);

    // R6 R8 CHR swap and bank write
    wr(16'h8000, 8'h80);
    wr(16'h8001, 8'h21);
    chr_is("R8 swapped w4->reg0 even", 13'h1000, 9'h120);
    chr_is("R8 swapped w5->reg0 odd", 13'h1400, 9'h121);
    chr_is("R8 swapped w0->reg2", 13'h0000, 9'h104);

    // R6 mirrored decode addresses
    wr(16'h9FFE, 8'h43);
    wr(16'h9FFF, 8'h55);
    chr_is("R6 R8 reg3 via 9FFF", 13'h1400, 9'h155);
    prg_is("R7 swap 8000 fixed", 16'h8000, 8'hFE);
    prg_is("R7 swap C000 reg6", 16'hC000, 8'hFC);
    wr(16'h8000, 8'h46);
    wr(16'h8001, 8'h12);
    prg_is("R7 reg6 swapped", 16'hC000, 8'h12);
    prg_is("R7 reg7", 16'hA000, 8'hFD);
    wr(16'hA000, 8'h01);
    probe(16'h8000, 13'h0);
    check("R5 R6 idx mirr", 32'(mirr_sel), 32'd3);
    wr(16'hA001, 8'h00);
    probe(16'h8000, 13'h0);
    check("R6 A001 ignored", 32'(mirr_sel), 32'd3);
    wr(16'hC000, 8'h77);
    wr(16'hE001, 8'h77);
    prg_is("R6 C000/E001 no bank effect", 16'hC000, 8'h12);

    // R12 back to nibble mapper
    wr(16'h4100, 8'h00);
    prg_is("R12 prg0 kept", 16'h8000, 8'h21);
    chr_is("R12 chr0 kept", 13'h0000, 9'h0A3);
    check("R12 mirr kept", 32'(mirr_sel), 32'd2);
    wr(16'h4100, 8'h04);
    chr_is("R2 mode4 high bit", 13'h0000, 9'h1A3);

    // R9 R10 serial mapper table
    wr(16'h4100, 8'h06);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ser_ctrl = TBL[i].ctrl; ser_chr_lo = TBL[i].clo;
      ser_chr_hi = TBL[i].chi; ser_prg = TBL[i].prg;
      cpu_addr = TBL[i].a; ppu_addr = TBL[i].p;
      #1;
      check($sformatf("R9 prg vec%0d", i), {11'd0, prg_addr}, {11'd0, TBL[i].exp_prg, TBL[i].a[12:0]});
      check($sformatf("R10 R2 chr vec%0d", i), {13'd0, chr_addr}, {13'd0, TBL[i].exp_chr, TBL[i].p[9:0]});
      check($sformatf("R10 mirr vec%0d", i), 32'(mirr_sel), 32'(TBL[i].exp_mir));
    end

    // R2 mode 3 is also serial mapper; R12 writes to ROM space ignored
    wr(16'h4100, 8'h03);
    wr(16'h8000, 8'h00);
    probe(16'hC000, 13'h0800);
    check("R2 mode3 serial prg", {11'd0, prg_addr}, {11'd0, 8'h1E, 13'h0000});
    check("R2 mode3 serial chr", {13'd0, chr_addr}, {13'd0, 9'h00A, 10'h000});
    wr(16'h4100, 8'h01);
    prg_is("R12 idx reg6 kept", 16'hC000, 8'h12);
    chr_is("R12 idx reg3 kept", 13'h1400, 9'h055);

    report();
  end

endmodule